// File: doc/BRIEF.md
# Bus Initiator Termination Controller

This block is the part of a parallel-bus initiator that decides how a burst ends. It owns the two active-low initiator strobes, frame and initiator-ready, and moves them through the address phase, the data phases and the return to idle. A request gives a transfer kind, a start address and a DWORD count. The block then stops the burst on the rule that fits that kind: one DWORD, a prefetch boundary, the end of the posted data, or a latency timer that has run out while the grant is gone. It also stops when the target signals retry, disconnect or abort.

The block counts five clocks from the moment frame goes low. If the target never claims the cycle in that window, it ends the cycle as a master abort. When a posted write is cut short by the latency timer, it keeps the address of the next undelivered DWORD and the remaining count, and it starts a new transaction for the rest as soon as the grant comes back. Each time the bus goes idle, the block gives a one-cycle completion pulse together with a status code. It also gives a one-cycle strobe for each data phase that completed.

Top module: `bus_term_ctrl`

## Requirements
- R1: After the synchronous active-high reset, `frame_n` and `irdy_n` are high, and `done`, `data_stb` and `busy` are low.
- R2: A request is accepted on a clock where the block is idle and `gnt_n` is low. For the next cycle `frame_n` is low and `irdy_n` is high (the address phase). After that, `irdy_n` is low.
- R3: `frame_n` rises only while `irdy_n` is low. It rises at the start of the final data phase. On a normal ending, `irdy_n` rises on the clock after the final data phase completes. In that same cycle `done` pulses with status 1 (normal).
- R4: A data phase completes only on a clock where `irdy_n`, `trdy_n` and `devsel_n` are all sampled low. `data_stb` is high for one cycle after each such clock.
- R5: Kind 0 (delayed write) and kind 1 (non-prefetchable read) transfer exactly one DWORD.
- R6: Kind 2 (prefetchable read) ends at the next PF_BYTES-aligned boundary. It transfers PF_BYTES/4 minus the start address's DWORD offset within the boundary.
- R7: Kind 3 (posted write) transfers `req_count` DWORDs (count at least 1).
- R8: While `gnt_n` is high and the latency timer has run out, the burst is ended. The timer is loaded from `lat_timer` at acceptance and is empty from the (lat_timer+1)-th clock after frame falls, so with zero-wait targets a cut burst carries lat_timer+1 DWORDs. A posted write flagged with `req_mwi` is exempt.
- R9: If `devsel_n` is not sampled low on any of the five clocks after frame falls, the cycle ends as a master abort with status 2. If frame is still low at that point, `frame_n` rises on that clock with `irdy_n` low, and `irdy_n` rises on the next clock. A target that answers on the fifth clock avoids the abort.
- R10: On a master abort that happens after frame is already high, `irdy_n` rises on the clock that detects the abort.
- R11: A stop from the target ends the cycle with one of three statuses. It is retry (3) when `devsel_n` is low, `trdy_n` is high and no data has moved yet. It is disconnect (4) when `devsel_n` is low otherwise, and a DWORD moves if `trdy_n` is low too. It is target abort (5) when `devsel_n` is high after having been low.
- R12: A posted write cut by R8 is restarted as a new transaction. `tx_addr` equals the start address plus 4 times the DWORDs already delivered, and the transaction carries the remaining count. A `done` pulse is given per transaction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Transfer request present |
| req_kind | input | 2 | 0 delayed write, 1 non-prefetchable read, 2 prefetchable read, 3 posted write |
| req_mwi | input | 1 | Posted write is a memory-write-and-invalidate (no latency cut) |
| req_addr | input | AW | Start byte address (DWORD aligned) |
| req_count | input | CW | DWORD count for posted writes |
| lat_timer | input | LW | Latency timer value loaded at acceptance |
| gnt_n | input | 1 | Bus grant, active low |
| devsel_n | input | 1 | Target claim, active low |
| trdy_n | input | 1 | Target ready, active low |
| stop_n | input | 1 | Target stop request, active low |
| frame_n | output | 1 | Cycle frame, active low |
| irdy_n | output | 1 | Initiator ready, active low |
| busy | output | 1 | Transaction in progress or restart pending |
| tx_addr | output | AW | Start address of the current transaction |
| data_stb | output | 1 | One-cycle pulse after each completed data phase |
| done | output | 1 | One-cycle pulse when the bus returns to idle |
| status | output | 3 | Ending of the last transaction: 1 normal, 2 master abort, 3 retry, 4 disconnect, 5 target abort |

## Verification
The remaining-count register, the five-clock claim counter and the latency timer all show up at the ports within a clock or two of going wrong. A bad remainder moves the rising edge of `frame_n` to a different data phase, so the number of DWORDs seen on the bus changes and the `done` pulse lands on a different clock. A stale claim counter either ends a claimed cycle as a master abort or lets an unclaimed one run past five clocks, and the `frame_n`/`irdy_n` low-cycle counts show it. A wrong next-DWORD address appears on `tx_addr` at the very first clock of a restarted posted write.

// File: rtl/bt_pkg.sv
package bt_pkg;
  typedef enum logic [1:0] {
    K_DLY_WR  = 2'd0,
    K_NP_RD   = 2'd1,
    K_PF_RD   = 2'd2,
    K_PST_WR  = 2'd3
  } kind_e;

  typedef enum logic [2:0] {
    ST_NONE   = 3'd0,
    ST_NORMAL = 3'd1,
    ST_MABORT = 3'd2,
    ST_RETRY  = 3'd3,
    ST_DISC   = 3'd4,
    ST_TABORT = 3'd5
  } stat_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2,
    PH_TAIL = 2'd3
  } ph_e;
endpackage

// File: rtl/bt_lat_timer.sv
module bt_lat_timer #(
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [LW-1:0] value,
  output logic          expired
);
  logic [LW-1:0] lt_q;

  always_ff @(posedge clk) begin
    if (rst)               lt_q <= '0;
    else if (load)         lt_q <= value;
    else if (lt_q != '0)   lt_q <= lt_q - LW'(1);
  end

  assign expired = (lt_q == '0);

  // once empty the timer stays empty until reloaded (R8)
  p_lat_stays_empty_r8: assert property (@(posedge clk) disable iff (rst)
    (!load && expired) |=> expired);
endmodule

// File: rtl/bt_abort_watch.sv
module bt_abort_watch #(
  parameter int MA_CLKS = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic active,
  input  logic devsel_n,
  output logic seen,
  output logic fire
);
  localparam int CNTW = (MA_CLKS > 1) ? $clog2(MA_CLKS) : 1;
  localparam logic [CNTW-1:0] LAST = CNTW'(MA_CLKS - 1);

  logic [CNTW-1:0] cnt_q;
  logic            seen_q;

  always_ff @(posedge clk) begin
    if (rst || arm) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else if (active && !seen_q) begin
      if (!devsel_n)          seen_q <= 1'b1;
      else if (cnt_q != LAST) cnt_q  <= cnt_q + CNTW'(1);
    end
  end

  assign seen = seen_q;
  assign fire = active && !seen_q && devsel_n && (cnt_q == LAST);

  // the controller leaves the claim window right after an abort (R9)
  p_abort_single_r9: assert property (@(posedge clk) disable iff (rst)
    fire |=> !fire);
endmodule

// File: rtl/bus_term_ctrl.sv
module bus_term_ctrl
  import bt_pkg::*;
#(
  parameter int AW       = 32,
  parameter int CW       = 8,
  parameter int LW       = 8,
  parameter int PF_BYTES = 64,
  parameter int MA_CLKS  = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [1:0]    req_kind,
  input  logic          req_mwi,
  input  logic [AW-1:0] req_addr,
  input  logic [CW-1:0] req_count,
  input  logic [LW-1:0] lat_timer,
  input  logic          gnt_n,
  input  logic          devsel_n,
  input  logic          trdy_n,
  input  logic          stop_n,
  output logic          frame_n,
  output logic          irdy_n,
  output logic          busy,
  output logic [AW-1:0] tx_addr,
  output logic          data_stb,
  output logic          done,
  output logic [2:0]    status
);
  localparam int PF_LSB = $clog2(PF_BYTES);
  localparam int PF_DW  = PF_BYTES / 4;
  localparam int OFFW   = PF_LSB - 2;

  ph_e           ph_q;
  kind_e         kind_q;
  stat_e         stat_q;
  logic          frame_q, irdy_q, mwi_q, got_q, pend_q, done_q, dstb_q;
  logic [AW-1:0] cur_q, tx_q;
  logic [CW-1:0] rem_q;

  logic          start, seen, ma_fire, lat_exp, lat_end;
  logic          xfer, stop_hit, ending;
  logic [CW-1:0] rem_nx, rem_in;
  kind_e         kind_in;
  logic [AW-1:0] addr_in;
  logic [OFFW-1:0] pf_off;

  assign start = (ph_q == PH_IDLE) && !gnt_n && (pend_q || req_valid);

  bt_lat_timer #(.LW(LW)) u_lat (
    .clk(clk), .rst(rst), .load(start), .value(lat_timer), .expired(lat_exp)
  );

  bt_abort_watch #(.MA_CLKS(MA_CLKS)) u_ma (
    .clk(clk), .rst(rst), .arm(start),
    .active((ph_q == PH_ADDR) || (ph_q == PH_DATA)),
    .devsel_n(devsel_n), .seen(seen), .fire(ma_fire)
  );

  always_comb begin
    pf_off  = req_addr[PF_LSB-1:2];
    kind_in = pend_q ? K_PST_WR : kind_e'(req_kind);
    addr_in = pend_q ? cur_q : req_addr;
    if (pend_q) rem_in = rem_q;
    else begin
      case (kind_e'(req_kind))
        K_PF_RD:  rem_in = CW'(PF_DW) - CW'(pf_off);
        K_PST_WR: rem_in = req_count;
        default:  rem_in = CW'(1);
      endcase
    end
  end

  assign xfer     = (ph_q == PH_DATA) && !trdy_n && !devsel_n && !ma_fire;
  assign stop_hit = (ph_q == PH_DATA) && (seen || !devsel_n) && !stop_n && !ma_fire;
  assign rem_nx   = rem_q - CW'(xfer);
  assign lat_end  = lat_exp && gnt_n && !(mwi_q && kind_q == K_PST_WR);
  assign ending   = (rem_nx == CW'(1)) || lat_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q    <= PH_IDLE;
      frame_q <= 1'b1;
      irdy_q  <= 1'b1;
      kind_q  <= K_DLY_WR;
      mwi_q   <= 1'b0;
      got_q   <= 1'b0;
      pend_q  <= 1'b0;
      done_q  <= 1'b0;
      dstb_q  <= 1'b0;
      stat_q  <= ST_NONE;
      cur_q   <= '0;
      tx_q    <= '0;
      rem_q   <= '0;
    end else begin
      done_q <= 1'b0;
      dstb_q <= xfer;
      case (ph_q)
        PH_IDLE: if (start) begin
          ph_q    <= PH_ADDR;
          frame_q <= 1'b0;
          kind_q  <= kind_in;
          if (!pend_q) mwi_q <= req_mwi;
          cur_q   <= addr_in;
          tx_q    <= addr_in;
          rem_q   <= rem_in;
          got_q   <= 1'b0;
          pend_q  <= 1'b0;
        end
        PH_ADDR: begin
          ph_q   <= PH_DATA;
          irdy_q <= 1'b0;
          if (rem_q == CW'(1) || lat_end) frame_q <= 1'b1;
        end
        PH_DATA: begin
          if (xfer) begin
            cur_q <= cur_q + AW'(4);
            rem_q <= rem_nx;
            got_q <= 1'b1;
          end
          if (ma_fire) begin
            stat_q <= ST_MABORT;
            if (!frame_q) begin
              frame_q <= 1'b1;
              ph_q    <= PH_TAIL;
            end else begin
              irdy_q <= 1'b1;
              ph_q   <= PH_IDLE;
              done_q <= 1'b1;
            end
          end else if (stop_hit) begin
            if (devsel_n)               stat_q <= ST_TABORT;
            else if (trdy_n && !got_q)  stat_q <= ST_RETRY;
            else                        stat_q <= ST_DISC;
            if (!frame_q) begin
              frame_q <= 1'b1;
              ph_q    <= PH_TAIL;
            end else begin
              irdy_q <= 1'b1;
              ph_q   <= PH_IDLE;
              done_q <= 1'b1;
            end
          end else if (xfer && frame_q) begin
            irdy_q <= 1'b1;
            ph_q   <= PH_IDLE;
            done_q <= 1'b1;
            stat_q <= ST_NORMAL;
            pend_q <= (kind_q == K_PST_WR) && (rem_nx != '0);
          end else if (!frame_q && ending) begin
            frame_q <= 1'b1;
          end
        end
        default: begin
          irdy_q <= 1'b1;
          ph_q   <= PH_IDLE;
          done_q <= 1'b1;
        end
      endcase
    end
  end

  assign frame_n  = frame_q;
  assign irdy_n   = irdy_q;
  assign busy     = (ph_q != PH_IDLE) || pend_q;
  assign tx_addr  = tx_q;
  assign data_stb = dstb_q;
  assign done     = done_q;
  assign status   = stat_q;

  // address phase: frame falls while initiator-ready is still high (R2)
  p_addr_phase_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(frame_n) |-> irdy_n);

  // frame is released only while initiator-ready is held low (R3)
  p_frame_rise_irdy_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(frame_n) |-> !irdy_n);

  // a completed final data phase releases initiator-ready next clock (R3)
  p_irdy_release_r3: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_DATA && frame_n && !irdy_n && !trdy_n && !devsel_n) |=> irdy_n);

  // the strobe follows a clock with both readies and the claim low (R4)
  p_strobe_cause_r4: assert property (@(posedge clk) disable iff (rst)
    data_stb |-> $past(!irdy_n && !trdy_n && !devsel_n));

  // a data phase never runs with nothing left to move (R7)
  p_rem_live_r7: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_DATA) |-> (rem_q != '0));

  // completion is reported only with the bus idle (R11)
  p_done_idle_r11: assert property (@(posedge clk) disable iff (rst)
    done |-> (frame_n && irdy_n));
endmodule

// File: tb/bus_term_ctrl_tb_top.sv
module bus_term_ctrl_tb_top;
  localparam int AW = 16, CW = 6, LW = 4, PFB = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [1:0] req_kind = '0;
  logic req_mwi = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [CW-1:0] req_count = '0;
  logic [LW-1:0] lat_timer = '0;
  logic gnt_n = 1'b1, devsel_n = 1'b1, trdy_n = 1'b1, stop_n = 1'b1;
  logic frame_n, irdy_n, busy, data_stb, done;
  logic [AW-1:0] tx_addr;
  logic [2:0] status;

  int total = 0, bad = 0, cycles = 0;
  int r_x, r_stb, r_segs, r_stat, r_flo, r_ilo, r_viol, r_aviol, r_edge, r_addr;

  always #2 clk = ~clk;

  bus_term_ctrl #(.AW(AW), .CW(CW), .LW(LW), .PF_BYTES(PFB), .MA_CLKS(5)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
    .req_mwi(req_mwi), .req_addr(req_addr), .req_count(req_count),
    .lat_timer(lat_timer), .gnt_n(gnt_n), .devsel_n(devsel_n),
    .trdy_n(trdy_n), .stop_n(stop_n), .frame_n(frame_n), .irdy_n(irdy_n),
    .busy(busy), .tx_addr(tx_addr), .data_stb(data_stb), .done(done),
    .status(status)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // smode: 0 retry, 1 disconnect with data, 2 disconnect without data, 3 target abort
  task automatic run(input int kind, input int addr, input int cnt, input bit mwi,
                     input int lat, input int d, input int w, input int s,
                     input int smode, input bit ghi, input int exp_segs);
    int k, cyc, last_e;
    bit in_t, stopped, pf;
    r_x = 0; r_stb = 0; r_segs = 0; r_stat = 0; r_flo = 0; r_ilo = 0;
    r_viol = 0; r_aviol = 0; r_edge = 0; r_addr = 0;
    k = 0; cyc = 0; last_e = 0; in_t = 0; stopped = 0; pf = 1;
    @(negedge clk);
    req_valid = 1; req_kind = kind[1:0]; req_mwi = mwi;
    req_addr = AW'(addr); req_count = CW'(cnt); lat_timer = LW'(lat); gnt_n = 0;
    while (r_segs < exp_segs && cyc < 400) begin
      @(negedge clk);
      cyc++;
      if (data_stb) r_stb++;
      if (!pf && frame_n && irdy_n) r_viol++;
      if (!frame_n) r_flo++;
      if (!irdy_n) r_ilo++;
      if (!frame_n && !in_t) begin
        in_t = 1; k = 0; stopped = 0; req_valid = 0;
        if (!irdy_n) r_aviol++;
        if (tx_addr != AW'(addr + 4 * r_x)) r_addr++;
      end else if (in_t) k++;
      if (done) begin
        r_segs++; r_stat = int'(status);
        if (status == 3'd1 && k != last_e) r_edge++;
        in_t = 0;
      end
      pf = frame_n;
      if (in_t) begin
        int e;
        bit on;
        e = k + 1;
        on = (e >= d) && !stopped;
        devsel_n = !on;
        trdy_n = !(on && (e % (w + 1) == 0));
        stop_n = 1;
        if (on && e == s) begin
          stop_n = 0; stopped = 1;
          case (smode)
            0: trdy_n = 1;
            1: trdy_n = 0;
            2: trdy_n = 1;
            default: begin devsel_n = 1; trdy_n = 1; end
          endcase
        end
        gnt_n = ghi;
        if (!irdy_n && !trdy_n && !devsel_n) begin r_x++; last_e = e; end
      end else begin
        devsel_n = 1; trdy_n = 1; stop_n = 1; gnt_n = 0;
      end
    end
    if (cyc >= 400) check(0, "run timeout", cyc, 400);
    devsel_n = 1; trdy_n = 1; stop_n = 1; req_valid = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(frame_n && irdy_n, "R1 strobes high in reset", {frame_n, irdy_n}, 3);
    rst = 0;
    @(negedge clk);
    check(frame_n && irdy_n && !done && !data_stb && !busy, "R1 idle after reset",
          {frame_n, irdy_n, done, data_stb, busy}, 5'b11000);

    for (int kd = 0; kd < 2; kd++) begin
      run(kd, 'h100, 5, 0, 15, 1, 0, 0, 0, 0, 1);
      check(r_x == 1, "R5 single dword", r_x, 1);
      check(r_stat == 1, "R3 normal status", r_stat, 1);
      check(r_edge == 0, "R3 irdy release clock", r_edge, 0);
      check(r_aviol == 0, "R2 address phase", r_aviol, 0);
      check(r_viol == 0, "R3 frame rises with irdy low", r_viol, 0);
    end

    for (int off = 0; off < PFB / 4; off++) begin
      run(2, 'h40 + 4 * off, 0, 0, 15, 1, 0, 0, 0, 0, 1);
      check(r_x == PFB / 4 - off, "R6 prefetch boundary", r_x, PFB / 4 - off);
      check(r_edge == 0, "R3 prefetch release clock", r_edge, 0);
    end

    for (int n = 1; n <= 6; n++) begin
      run(3, 'h200, n, 0, 15, 1, 0, 0, 0, 0, 1);
      check(r_x == n, "R7 posted count", r_x, n);
      check(r_stb == n, "R4 strobe count", r_stb, n);
      check(r_edge == 0 && r_stat == 1, "R3 posted ending", r_edge, 0);
    end

    run(3, 'h300, 4, 0, 15, 1, 1, 0, 0, 0, 1);
    check(r_x == 4 && r_stb == 4, "R4 wait states", r_stb, 4);

    for (int d = 1; d <= 5; d++) begin
      run(3, 'h400, 3, 0, 15, d, 0, 0, 0, 0, 1);
      check(r_stat == 1 && r_x == 3, "R9 claim inside window", r_stat, 1);
    end

    run(3, 'h500, 4, 0, 15, 99, 0, 0, 0, 0, 1);
    check(r_stat == 2, "R9 master abort status", r_stat, 2);
    check(r_flo == 5, "R9 frame low clocks", r_flo, 5);
    check(r_ilo == 5, "R9 irdy low clocks", r_ilo, 5);
    check(r_viol == 0 && r_x == 0, "R9 frame rise with irdy", r_viol, 0);

    for (int kd = 0; kd < 2; kd++) begin
      run(kd, 'h600, 1, 0, 15, 99, 0, 0, 0, 0, 1);
      check(r_stat == 2, "R10 master abort status", r_stat, 2);
      check(r_flo == 1 && r_ilo == 4, "R10 irdy low clocks", r_ilo, 4);
    end

    run(3, 'h700, 8, 0, 15, 1, 0, 2, 0, 0, 1);
    check(r_stat == 3 && r_x == 0, "R11 retry", r_stat, 3);
    run(3, 'h700, 8, 0, 15, 1, 0, 4, 1, 0, 1);
    check(r_stat == 4 && r_x == 3, "R11 disconnect with data", r_x, 3);
    run(3, 'h700, 8, 0, 15, 1, 0, 4, 2, 0, 1);
    check(r_stat == 4 && r_x == 2, "R11 disconnect without data", r_x, 2);
    run(3, 'h700, 8, 0, 15, 1, 0, 4, 3, 0, 1);
    check(r_stat == 5 && r_x == 2, "R11 target abort", r_stat, 5);
    check(r_viol == 0, "R3 frame rise on stop", r_viol, 0);

    for (int l = 0; l <= 4; l++) begin
      int segs;
      segs = (10 + l) / (l + 1);
      run(3, 'h800, 10, 0, l, 1, 0, 0, 0, 1, segs);
      check(r_segs == segs, "R8 latency segments", r_segs, segs);
      check(r_x == 10 && r_stb == 10, "R12 total after restarts", r_x, 10);
      check(r_addr == 0, "R12 restart address", r_addr, 0);
    end

    run(3, 'h900, 6, 1, 1, 1, 0, 0, 0, 1, 1);
    check(r_x == 6 && !busy, "R8 invalidate write not cut", r_x, 6);
    run(2, 'h900, 0, 0, 1, 1, 0, 0, 0, 1, 1);
    check(r_x == 2 && !busy, "R8 prefetch cut no restart", r_x, 2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule